// File: doc/BRIEF.md
# Four-Operand Compressor Adder with Negation Correction

This block sums four 8-bit two's-complement operands in one combinational pass and returns a 10-bit result. Every operand is first sign-extended to the result width. A row of (4,2) compressors, one per result bit, reduces the four operands to a sum vector and a carry vector. A ripple carry-propagate adder then merges the two vectors.

The same unit also computes a difference. A caller that wants w + x - y - z inverts y and z bit by bit before it presents them, and raises the subtract mode input. Each inverted operand is one short of its negation, so the unit adds two by injecting a one at result bit 1. That injection goes into the carry-propagate adder at the one slot that the shifted carry vector always leaves empty. No extra compressor stage is needed.

Top module: `quad_compress_adder`

## Requirements
- R1: Operands opW, opX, opY and opZ are 8-bit two's-complement values, and sumOut is a 10-bit two's-complement value.
- R2: With subMode low, sumOut equals opW + opX + opY + opZ taken modulo 1024.
- R3: Each bit-slice compressor is built only from AND, OR and XOR. The count of ones on its five inputs (four operand bits plus carry-in) equals sum + 2*carry + 2*carryOut.
- R4: The carry-out of each slice feeds the carry-in of the next higher slice, and the carry-in of slice 0 is zero. Operands with long runs of ones therefore sum correctly across every bit.
- R5: With subMode high, a constant one is added at bit position 1 (weight two). With opY and opZ given as the bitwise inverse of y and z, sumOut equals w + x - y - z modulo 1024.
- R6: Operands are sign-extended, so negative and extreme inputs give the exact sum. All four at -128 gives 10'h200, and all four at 127 gives 10'h1FC.
- R7: The block is purely combinational. sumOut follows its inputs without waiting for any clock edge.
- R8: With subMode high and all four operand inputs zero, sumOut is 2. With subMode low and all four operand inputs zero, sumOut is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opW | input | 8 | First operand, two's complement |
| opX | input | 8 | Second operand, two's complement |
| opY | input | 8 | Third operand, pre-inverted by the caller when subtracting |
| opZ | input | 8 | Fourth operand, pre-inverted by the caller when subtracting |
| subMode | input | 1 | High: add the +2 correction for two inverted operands |
| sumOut | output | 10 | Result, modulo 1024 |

## Verification
The assertions assume the five inputs carry known values whenever they are evaluated, and they check nothing while any input is unknown. The correction-slot check also assumes that the shifted carry vector always presents a zero in bit 0, which the row guarantees for any legal operand. The bench holds every input at a defined value from the first cycle and changes inputs only between sampling points. In subtract mode it always hands the design the bitwise inverse of y and z, which is the contract the +2 correction relies on.

// File: rtl/fca_pkg.sv
package fca_pkg;
  // Strobes from control to datapath.
  typedef struct packed {
    logic addTwo;   // inject weight-two correction into the merge adder
  } fcaStrobe_t;
endpackage

// File: rtl/fca_ctrl.sv
module fca_ctrl
  import fca_pkg::*;
(
  input  logic       subMode,
  output fcaStrobe_t strobe
);
  // Two inverted operands each fall one short of their negation.
  assign strobe.addTwo = subMode;
endmodule

// File: rtl/fca_compressor42.sv
module fca_compressor42 (
  input  logic a,
  input  logic b,
  input  logic c,
  input  logic d,
  input  logic cin,
  output logic sum,
  output logic carry,
  output logic cout
);
  logic abx, s1, s1d;

  // First full-adder stage on a, b, c: carry-out leaves the slice early.
  assign abx  = a ^ b;
  assign s1   = abx ^ c;
  assign cout = (a & b) | (c & abx);

  // Second stage merges d and the neighbour's carry-in.
  assign s1d   = s1 ^ d;
  assign sum   = s1d ^ cin;
  assign carry = (s1 & d) | (cin & s1d);

  always_comb begin
    if (!$isunknown({a, b, c, d, cin})) begin
      assert_count_R3: assert (3'(sum) + 3'({carry, 1'b0}) + 3'({cout, 1'b0})
                               == 3'($countones({a, b, c, d, cin})))
        else $error("compressor weight mismatch");
    end
  end
endmodule

// File: rtl/fca_cpa.sv
module fca_cpa #(
  parameter int W       = 10,
  parameter int INJ_POS = 1
) (
  input  logic [W-1:0] addA,
  input  logic [W-1:0] addB,
  input  logic         inject,
  output logic [W-1:0] result
);
  logic [W:0] rip;

  always_comb begin
    rip[0] = 1'b0;
    for (int i = 0; i < W; i++) begin
      result[i] = addA[i] ^ addB[i] ^ rip[i];
      rip[i+1]  = (addA[i] & addB[i]) | (rip[i] & (addA[i] ^ addB[i]));
      if (i + 1 == INJ_POS) rip[i+1] = rip[i+1] | inject;
    end
  end

  logic unusedTopCarry;
  assign unusedTopCarry = rip[W];

  // The OR-injection is exact only when nothing below the slot can carry.
  always_comb begin
    if (!$isunknown({inject, addB})) begin
      if (inject) begin
        assert_slot_free_R5: assert (addB[INJ_POS-1:0] == '0)
          else $error("correction slot occupied");
      end
    end
  end
endmodule

// File: rtl/fca_datapath.sv
module fca_datapath
  import fca_pkg::*;
#(
  parameter int OP_W  = 8,
  parameter int RES_W = OP_W + 2
) (
  input  logic [OP_W-1:0]  opW,
  input  logic [OP_W-1:0]  opX,
  input  logic [OP_W-1:0]  opY,
  input  logic [OP_W-1:0]  opZ,
  input  fcaStrobe_t       strobe,
  output logic [RES_W-1:0] result
);
  localparam int EXT_W = RES_W - OP_W;

  logic [RES_W-1:0] extW, extX, extY, extZ;
  logic [RES_W-1:0] sumVec, carVec, carShift;
  logic [RES_W:0]   chain;

  assign extW = {{EXT_W{opW[OP_W-1]}}, opW};
  assign extX = {{EXT_W{opX[OP_W-1]}}, opX};
  assign extY = {{EXT_W{opY[OP_W-1]}}, opY};
  assign extZ = {{EXT_W{opZ[OP_W-1]}}, opZ};

  assign chain[0] = 1'b0;

  for (genvar i = 0; i < RES_W; i++) begin : g_slice
    fca_compressor42 u_cmp (
      .a    (extW[i]),
      .b    (extX[i]),
      .c    (extY[i]),
      .d    (extZ[i]),
      .cin  (chain[i]),
      .sum  (sumVec[i]),
      .carry(carVec[i]),
      .cout (chain[i+1])
    );
  end

  logic [1:0] unusedOverflow;
  assign unusedOverflow = {chain[RES_W], carVec[RES_W-1]};

  assign carShift = {carVec[RES_W-2:0], 1'b0};

  fca_cpa #(.W(RES_W), .INJ_POS(1)) u_cpa (
    .addA  (sumVec),
    .addB  (carShift),
    .inject(strobe.addTwo),
    .result(result)
  );

  always_comb begin
    if (!$isunknown({opW, opX, opY, opZ, strobe})) begin
      assert_row_total_R4: assert (RES_W'(sumVec + carShift)
                                   == RES_W'(extW + extX + extY + extZ))
        else $error("compressor row lost weight");
      assert_merge_R5: assert (result == RES_W'(sumVec + carShift
                                   + (strobe.addTwo ? RES_W'(2) : RES_W'(0))))
        else $error("merge adder mismatch");
    end
  end
endmodule

// File: rtl/quad_compress_adder.sv
module quad_compress_adder
  import fca_pkg::*;
#(
  parameter int OP_W  = 8,
  parameter int RES_W = OP_W + 2
) (
  input  logic [OP_W-1:0]  opW,
  input  logic [OP_W-1:0]  opX,
  input  logic [OP_W-1:0]  opY,
  input  logic [OP_W-1:0]  opZ,
  input  logic             subMode,
  output logic [RES_W-1:0] sumOut
);
  fcaStrobe_t strobe;

  fca_ctrl u_ctrl (
    .subMode(subMode),
    .strobe (strobe)
  );

  fca_datapath #(.OP_W(OP_W), .RES_W(RES_W)) u_dp (
    .opW   (opW),
    .opX   (opX),
    .opY   (opY),
    .opZ   (opZ),
    .strobe(strobe),
    .result(sumOut)
  );

  always_comb begin
    if (!$isunknown({opW, opX, opY, opZ, subMode})) begin
      if (!subMode) begin
        assert_plain_sum_R2: assert (sumOut == RES_W'(int'($signed(opW)) + int'($signed(opX))
                                     + int'($signed(opY)) + int'($signed(opZ))))
          else $error("plain sum wrong");
      end else begin
        assert_corrected_sum_R5: assert (sumOut == RES_W'(int'($signed(opW)) + int'($signed(opX))
                                     + int'($signed(opY)) + int'($signed(opZ)) + 2))
          else $error("corrected sum wrong");
      end
    end
  end
endmodule

// File: tb/sim_quad_compress_adder.sv
module sim_quad_compress_adder;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] opW = '0, opX = '0, opY = '0, opZ = '0;
  logic       subMode = 1'b0;
  logic [9:0] sumOut;
  int         nChecks = 0;
  int         nFails  = 0;
  int         cycles  = 0;
  bit         done    = 1'b0;

  always #5 clk = ~clk;

  quad_compress_adder u0 (
    .opW(opW), .opX(opX), .opY(opY), .opZ(opZ),
    .subMode(subMode), .sumOut(sumOut)
  );

  function automatic logic [9:0] model(int a, int b, int c, int d, bit sub);
    int t;
    t = sub ? (a + b - c - d) : (a + b + c + d);
    return 10'(t);
  endfunction

  task automatic check(string tag, logic [9:0] got, logic [9:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Drive true operand values; in subtract mode y and z go in inverted.
  task automatic apply(int a, int b, int c, int d, bit sub);
    @(negedge clk);
    subMode = sub;
    opW = 8'(a);
    opX = 8'(b);
    opY = sub ? ~8'(c) : 8'(c);
    opZ = sub ? ~8'(d) : 8'(d);
    #2;
  endtask

  task automatic run(string tag, int a, int b, int c, int d, bit sub);
    apply(a, b, c, d, sub);
    check(tag, sumOut, model(a, b, c, d, sub));
  endtask

  task automatic t_reset_state;   // R8
    @(negedge clk); #2;
    check("R8 reset zero add", sumOut, 10'h000);
  endtask

  task automatic t_zero_sub;      // R8, R5
    @(negedge clk);
    subMode = 1'b1; opW = '0; opX = '0; opY = '0; opZ = '0;
    #2;
    check("R8 zero operands sub mode", sumOut, 10'h002);
  endtask

  task automatic t_plain;         // R2, R1
    run("R2 small", 1, 2, 3, 4, 0);
    run("R2 mixed sign", 100, -50, 7, -120, 0);
    run("R1 negatives", -1, -1, -1, -1, 0);
  endtask

  task automatic t_ripple;        // R4, R3
    run("R4 all ones low", 8'h7F, 8'h01, 8'h7F, 8'h01, 0);
    run("R3 alternating", 8'h55, 8'h2A, 8'h55, 8'h2A, 0);
    run("R4 ripple sub", 63, 64, -1, -1, 1);
  endtask

  task automatic t_sub;           // R5
    run("R5 basic", 10, 20, 3, 4, 1);
    run("R5 negative result", 0, 0, 100, 27, 1);
    run("R5 negative subtrahends", -7, 5, -9, -100, 1);
  endtask

  task automatic t_extremes;      // R6
    apply(-128, -128, -128, -128, 0);
    check("R6 all min", sumOut, 10'h200);
    apply(127, 127, 127, 127, 0);
    check("R6 all max", sumOut, 10'h1FC);
    run("R6 max minus min", 127, 127, -128, -128, 1);
    run("R6 min minus max", -128, -128, 127, 127, 1);
  endtask

  task automatic t_comb;          // R7
    @(negedge clk);
    subMode = 1'b0; opW = 8'd5; opX = 8'd6; opY = 8'd7; opZ = 8'd8;
    #1;
    check("R7 first value no edge", sumOut, 10'd26);
    opW = 8'd50;
    #1;
    check("R7 follows same phase", sumOut, 10'd71);
  endtask

  task automatic t_random;        // R2, R5
    int seed = 7;
    void'($urandom(seed));
    for (int i = 0; i < 300; i++) begin
      int a = int'($signed(8'($urandom)));
      int b = int'($signed(8'($urandom)));
      int c = int'($signed(8'($urandom)));
      int d = int'($signed(8'($urandom)));
      bit s = bit'($urandom);
      run(s ? "R5 random" : "R2 random", a, b, c, d, s);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    t_reset_state();
    t_plain();
    t_ripple();
    t_sub();
    t_zero_sub();
    t_extremes();
    t_comb();
    t_random();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (!done && cycles > 100000) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got %0d cycles expected completion", cycles);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule